// File: doc/BRIEF.md
# DMA Minor-Loop Address Generator

This block produces the source and destination byte addresses for one DMA channel, beat by beat, from a transfer descriptor. A start pulse latches the descriptor. From then on the block presents a beat, with its two addresses, until the beat is accepted. Each accepted beat adds a signed per-beat step to each address and adds the beat's byte size to a byte counter.

When the byte counter reaches the minor-loop byte count, the loop ends. A signed minor-loop offset, packed into the same 32-bit word as the byte count, can then be added to the source address, the destination address, or both. The major iteration count then drops by one. When it reaches zero, a last-adjustment value is added to each address and the count reloads, so a cyclic buffer wraps and the channel keeps running.

This arrangement supports a two-FIFO peripheral pattern. The device-side step is 4 and the minor-loop offset is -8. Beats then alternate between two adjacent 32-bit FIFO registers, and the address returns to the first register at every loop boundary. With a device-side step of 0, every beat uses one fixed FIFO address.

Top module: `dma_addr_gen`

## Requirements
- R1: While reset is high, beat_valid, minor_done and major_done are low and both addresses are zero.
- R2: A start pulse latches the descriptor. One cycle later both addresses equal the descriptor base addresses and beat_valid is high, unless the major count is zero, in which case beat_valid is low. Once high, beat_valid stays high until the next start.
- R3: The addresses change only on a cycle where beat_valid and beat_accept are both high. A beat that does not end a minor loop adds the sign-extended 16-bit source and destination steps.
- R4: The loop word holds a source offset enable at bit 31 and a destination offset enable at bit 30. If either enable is set, the minor-loop byte count is bits 9:0; otherwise it is bits 29:0.
- R5: A beat's size is 1, 2, 4 or 8 bytes (1 << desc_size). The beat that brings the accumulated byte total to or past the byte count ends the minor loop. minor_done is high for one cycle right after that beat, and the byte total restarts at zero.
- R6: At a minor-loop end, the signed offset in bits 29:10 is added (on top of the step) to each address whose enable is set. An address whose enable is clear receives only its step.
- R7: The minor loop that brings the remaining major count to zero also adds the source and destination last adjustments. It raises major_done together with minor_done, and it reloads the count from the descriptor value, so the channel keeps running and wraps.
- R8: Descriptor with the device-side step 4, offset -8 with only the device-side enable set, 4-byte beats and an 8-byte count: the device-side address alternates base, base+4, base on consecutive beats. This holds with the destination as the device side and with the source as the device side.
- R9: A device-side step of 0 with both enables clear keeps the device-side address fixed for every beat.
- R10: A start pulse while the channel is running discards the progress so far and restarts from the new descriptor.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Latch descriptor and restart |
| desc_src | input | AW | Source base address |
| desc_dst | input | AW | Destination base address |
| desc_src_step | input | SW | Signed per-beat source step |
| desc_dst_step | input | SW | Signed per-beat destination step |
| desc_loop_word | input | 32 | Packed byte count, minor-loop offset and enables |
| desc_src_last | input | AW | Source adjustment at major-loop end |
| desc_dst_last | input | AW | Destination adjustment at major-loop end |
| desc_major | input | CW | Major iteration count |
| desc_size | input | 2 | Beat size, log2 bytes |
| beat_accept | input | 1 | Current beat taken |
| src_addr | output | AW | Source address of current beat |
| dst_addr | output | AW | Destination address of current beat |
| beat_valid | output | 1 | A beat is offered |
| minor_done | output | 1 | One-cycle minor-loop end pulse |
| major_done | output | 1 | One-cycle major-loop end pulse |

## Verification
Each result has a fixed latency. A start pulse is seen in the addresses and beat_valid one edge later. An accepted beat moves the addresses to the next beat's values at the same edge that samples it. The minor_done and major_done pulses for that beat are visible in the cycle that follows that edge, for exactly one cycle. The bench drives inputs at the falling edge and advances its reference model once per rising edge, using the inputs it has just driven. It then compares every output at the next falling edge, so each comparison lines up with the cycle in which the design's registers have taken the new value.

// File: rtl/dmaag_pkg.sv
package dmaag_pkg;

    localparam int ADDR_W     = 32;
    localparam int COUNT_W    = 15;
    localparam int STEP_W     = 16;
    localparam int OFF_W      = 20;
    localparam int SHORT_NB_W = 10;
    localparam int LONG_NB_W  = 30;
    localparam int BEAT_B_W   = 4;

    // packed loop word; bit positions are decoded by behaviour
    typedef struct packed {
        logic                    src_ml_en;   // bit 31
        logic                    dst_ml_en;   // bit 30
        logic signed [OFF_W-1:0] ml_off;      // bits 29:10
        logic [SHORT_NB_W-1:0]   nb_short;    // bits 9:0
    } loop_word_t;

    typedef enum logic [1:0] {
        SZ_1B = 2'd0,
        SZ_2B = 2'd1,
        SZ_4B = 2'd2,
        SZ_8B = 2'd3
    } beat_size_e;

    function automatic logic [LONG_NB_W-1:0] nb_limit(input loop_word_t w);
        if (w.src_ml_en || w.dst_ml_en)
            return {{(LONG_NB_W-SHORT_NB_W){1'b0}}, w.nb_short};
        return {w.ml_off, w.nb_short};
    endfunction

    function automatic logic [BEAT_B_W-1:0] beat_bytes(input beat_size_e s);
        return BEAT_B_W'(1) << s;
    endfunction

endpackage

// File: rtl/dmaag_iter.sv
module dmaag_iter #(
    parameter int CW  = 15,
    parameter int LW  = 30,
    parameter int BBW = 4
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           load,
    input  logic [CW-1:0]  load_count,
    input  logic           fire,
    input  logic [BBW-1:0] beat_bytes,
    input  logic [LW-1:0]  limit,
    output logic           active,
    output logic           minor_end,
    output logic           major_end,
    output logic           minor_done,
    output logic           major_done
);
    logic [LW-1:0] byte_cnt;
    logic [LW:0]   bytes_next;
    logic [CW-1:0] citer;
    logic [CW-1:0] biter;

    always_comb begin
        bytes_next = {1'b0, byte_cnt} + {{(LW+1-BBW){1'b0}}, beat_bytes};
        minor_end  = fire && (bytes_next >= {1'b0, limit});
        major_end  = minor_end && (citer == CW'(1));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            byte_cnt   <= '0;
            citer      <= '0;
            biter      <= '0;
            active     <= 1'b0;
            minor_done <= 1'b0;
            major_done <= 1'b0;
        end else if (load) begin
            byte_cnt   <= '0;
            citer      <= load_count;
            biter      <= load_count;
            active     <= (load_count != '0);
            minor_done <= 1'b0;
            major_done <= 1'b0;
        end else begin
            minor_done <= minor_end;
            major_done <= major_end;
            if (fire) begin
                if (minor_end) begin
                    byte_cnt <= '0;
                    citer    <= major_end ? biter : citer - CW'(1);
                end else begin
                    byte_cnt <= bytes_next[LW-1:0];
                end
            end
        end
    end

    // R7
    count_live_chk: assert property (@(posedge clk) disable iff (rst)
        active |-> (citer != '0));

    // R5
    byte_below_limit_chk: assert property (@(posedge clk) disable iff (rst)
        (active && byte_cnt != '0) |-> (byte_cnt < limit));

    // R5
    minor_after_fire_chk: assert property (@(posedge clk) disable iff (rst)
        minor_done |-> $past(fire));

endmodule

// File: rtl/dmaag_addr.sv
module dmaag_addr #(
    parameter int AW = 32,
    parameter int SW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [AW-1:0] base,
    input  logic          fire,
    input  logic [SW-1:0] step,
    input  logic          minor_end,
    input  logic          ml_en,
    input  logic [AW-1:0] ml_off,
    input  logic          major_end,
    input  logic [AW-1:0] last,
    output logic [AW-1:0] addr
);
    logic [AW-1:0] step_ext;
    logic [AW-1:0] loop_add;
    logic [AW-1:0] wrap_add;
    logic [AW-1:0] addr_nxt;

    always_comb begin
        step_ext = {{(AW-SW){step[SW-1]}}, step};
        loop_add = (minor_end && ml_en) ? ml_off : '0;
        wrap_add = major_end ? last : '0;
        addr_nxt = addr + step_ext + loop_add + wrap_add;
    end

    always_ff @(posedge clk) begin
        if (rst)
            addr <= '0;
        else if (load)
            addr <= base;
        else if (fire)
            addr <= addr_nxt;
    end

    // R3
    addr_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!load && !fire) |=> $stable(addr));

endmodule

// File: rtl/dma_addr_gen.sv
module dma_addr_gen
    import dmaag_pkg::*;
#(
    parameter int AW = dmaag_pkg::ADDR_W,
    parameter int CW = dmaag_pkg::COUNT_W,
    parameter int SW = dmaag_pkg::STEP_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic [AW-1:0] desc_src,
    input  logic [AW-1:0] desc_dst,
    input  logic [SW-1:0] desc_src_step,
    input  logic [SW-1:0] desc_dst_step,
    input  logic [31:0]   desc_loop_word,
    input  logic [AW-1:0] desc_src_last,
    input  logic [AW-1:0] desc_dst_last,
    input  logic [CW-1:0] desc_major,
    input  logic [1:0]    desc_size,
    input  logic          beat_accept,
    output logic [AW-1:0] src_addr,
    output logic [AW-1:0] dst_addr,
    output logic          beat_valid,
    output logic          minor_done,
    output logic          major_done
);
    localparam int NCH = 2;

    loop_word_t               word_q;
    beat_size_e               size_q;
    logic [NCH-1:0][SW-1:0]   step_q;
    logic [NCH-1:0][AW-1:0]   last_q;
    logic [NCH-1:0][AW-1:0]   base_in;
    logic [NCH-1:0][AW-1:0]   addr_q;
    logic [NCH-1:0]           ml_en;
    logic [AW-1:0]            ml_off_ext;
    logic                     fire;
    logic                     minor_end;
    logic                     major_end;

    always_ff @(posedge clk) begin
        if (rst) begin
            word_q <= '0;
            size_q <= SZ_1B;
            step_q <= '0;
            last_q <= '0;
        end else if (start) begin
            word_q <= loop_word_t'(desc_loop_word);
            size_q <= beat_size_e'(desc_size);
            step_q <= {desc_dst_step, desc_src_step};
            last_q <= {desc_dst_last, desc_src_last};
        end
    end

    always_comb begin
        fire       = beat_valid && beat_accept && !start;
        base_in    = {desc_dst, desc_src};
        ml_en      = {word_q.dst_ml_en, word_q.src_ml_en};
        ml_off_ext = {{(AW-OFF_W){word_q.ml_off[OFF_W-1]}}, word_q.ml_off};
    end

    dmaag_iter #(
        .CW (CW),
        .LW (LONG_NB_W),
        .BBW(BEAT_B_W)
    ) iter_i (
        .clk       (clk),
        .rst       (rst),
        .load      (start),
        .load_count(desc_major),
        .fire      (fire),
        .beat_bytes(beat_bytes(size_q)),
        .limit     (nb_limit(word_q)),
        .active    (beat_valid),
        .minor_end (minor_end),
        .major_end (major_end),
        .minor_done(minor_done),
        .major_done(major_done)
    );

    for (genvar c = 0; c < NCH; c++) begin : g_side
        dmaag_addr #(
            .AW(AW),
            .SW(SW)
        ) addr_i (
            .clk      (clk),
            .rst      (rst),
            .load     (start),
            .base     (base_in[c]),
            .fire     (fire),
            .step     (step_q[c]),
            .minor_end(minor_end),
            .ml_en    (ml_en[c]),
            .ml_off   (ml_off_ext),
            .major_end(major_end),
            .last     (last_q[c]),
            .addr     (addr_q[c])
        );
    end

    assign src_addr = addr_q[0];
    assign dst_addr = addr_q[1];

    // R7
    major_with_minor_chk: assert property (@(posedge clk) disable iff (rst)
        major_done |-> minor_done);

    // R2
    valid_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (beat_valid && !start) |=> beat_valid);

    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        rst |=> (!beat_valid && !minor_done && !major_done));

endmodule

// File: tb/dma_addr_gen_tb.sv
module dma_addr_gen_tb_top;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst;
    logic        start;
    logic [31:0] d_src, d_dst, d_sl, d_dl, d_word;
    logic [15:0] d_ss, d_ds;
    logic [14:0] d_major;
    logic [1:0]  d_size;
    logic        accept;
    logic [31:0] src_addr, dst_addr;
    logic        beat_valid, minor_done, major_done;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    // reference model state
    logic        m_valid, m_min, m_maj;
    logic [31:0] m_src, m_dst, m_bytes, m_word, m_ss, m_ds, m_sl, m_dl;
    logic [14:0] m_citer, m_biter;
    logic [1:0]  m_size;

    always #(CLK_PERIOD/2) clk = ~clk;

    dma_addr_gen dut_i (
        .clk(clk), .rst(rst), .start(start),
        .desc_src(d_src), .desc_dst(d_dst),
        .desc_src_step(d_ss), .desc_dst_step(d_ds),
        .desc_loop_word(d_word),
        .desc_src_last(d_sl), .desc_dst_last(d_dl),
        .desc_major(d_major), .desc_size(d_size),
        .beat_accept(accept),
        .src_addr(src_addr), .dst_addr(dst_addr),
        .beat_valid(beat_valid), .minor_done(minor_done), .major_done(major_done)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] limit_of(input logic [31:0] w);
        // R4: short count when either enable set
        if (w[31] || w[30]) return {22'd0, w[9:0]};
        return {2'd0, w[29:0]};
    endfunction

    task automatic compare_all();
        string t;
        t = m_maj ? "R7" : (m_min ? "R5" : "R3");
        check("R2 valid", {31'd0, beat_valid}, {31'd0, m_valid});
        check({t, " src"}, src_addr, m_src);
        check({t, " dst"}, dst_addr, m_dst);
        check("R5 minor", {31'd0, minor_done}, {31'd0, m_min});
        check("R7 major", {31'd0, major_done}, {31'd0, m_maj});
    endtask

    task automatic do_start();
        accept = 1'b0;
        start  = 1'b1;
        m_src = d_src; m_dst = d_dst; m_word = d_word;
        m_ss = {{16{d_ss[15]}}, d_ss}; m_ds = {{16{d_ds[15]}}, d_ds};
        m_sl = d_sl; m_dl = d_dl; m_size = d_size;
        m_citer = d_major; m_biter = d_major; m_bytes = 0;
        m_valid = (d_major != 0); m_min = 0; m_maj = 0;
        @(posedge clk);
        @(negedge clk);
        start = 1'b0;
        compare_all();
    endtask

    task automatic tick(input logic acc);
        logic [31:0] bn, ns, nd, moff;
        accept = acc;
        m_min = 0; m_maj = 0;
        if (m_valid && acc) begin
            bn = m_bytes + (32'd1 << m_size);
            ns = m_src + m_ss;
            nd = m_dst + m_ds;
            moff = {{12{m_word[29]}}, m_word[29:10]};
            if (bn >= limit_of(m_word)) begin
                m_min = 1;
                if (m_word[31]) ns = ns + moff;   // R6
                if (m_word[30]) nd = nd + moff;
                m_bytes = 0;
                if (m_citer == 15'd1) begin
                    m_maj = 1;
                    ns = ns + m_sl;
                    nd = nd + m_dl;
                    m_citer = m_biter;
                end else begin
                    m_citer = m_citer - 15'd1;
                end
            end else begin
                m_bytes = bn;
            end
            m_src = ns; m_dst = nd;
        end
        @(posedge clk);
        @(negedge clk);
        compare_all();
    endtask

    function automatic logic [31:0] pack_word(input bit se, input bit de, input int off, input int nb);
        logic [31:0] o;
        o = off;
        return {se, de, o[19:0], 10'(nb)};
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog act=running exp=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int seen;
        void'($urandom(32'd4242));
        rst = 1'b1; start = 1'b0; accept = 1'b0;
        d_src = 0; d_dst = 0; d_sl = 0; d_dl = 0; d_word = 0;
        d_ss = 0; d_ds = 0; d_major = 0; d_size = 0;
        m_valid = 0; m_min = 0; m_maj = 0; m_src = 0; m_dst = 0;
        m_bytes = 0; m_word = 0; m_ss = 0; m_ds = 0; m_sl = 0; m_dl = 0;
        m_citer = 0; m_biter = 0; m_size = 0;
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1 valid", {31'd0, beat_valid}, 32'd0);
        check("R1 minor", {31'd0, minor_done}, 32'd0);
        check("R1 major", {31'd0, major_done}, 32'd0);
        check("R1 src", src_addr, 32'd0);
        check("R1 dst", dst_addr, 32'd0);
        rst = 1'b0;
        @(negedge clk);

        // R2 zero major count leaves the channel idle
        d_src = 32'h100; d_dst = 32'h200; d_major = 0; d_word = 32'd4;
        do_start();
        tick(1);
        check("R2 zero count", {31'd0, beat_valid}, 32'd0);

        // R8 memory to device, two destination FIFOs
        d_src = 32'h1000; d_ss = 16'd4; d_dst = 32'h8000_0000; d_ds = 16'd4;
        d_word = pack_word(0, 1, -8, 8); d_size = 2'd2; d_major = 3;
        d_sl = -32'd24; d_dl = 0;
        do_start();
        for (int k = 0; k < 12; k++) begin
            check("R8 dst fifo", dst_addr, 32'h8000_0000 + 32'(4 * (k % 2)));
            check("R7 src wrap", src_addr, 32'h1000 + 32'(4 * (k % 6)));
            tick(1);
            if (k == 5) check("R7 major pulse", {31'd0, major_done}, 32'd1);
        end

        // R8 device to memory, two source FIFOs
        d_src = 32'h4000_0010; d_ss = 16'd4; d_dst = 32'h2000; d_ds = 16'd4;
        d_word = pack_word(1, 0, -8, 8); d_sl = 0; d_dl = -32'd16; d_major = 2;
        do_start();
        for (int k = 0; k < 8; k++) begin
            check("R8 src fifo", src_addr, 32'h4000_0010 + 32'(4 * (k % 2)));
            check("R8 dst mem", dst_addr, 32'h2000 + 32'(4 * (k % 4)));
            tick(1);
        end

        // R9 fixed FIFO address
        d_src = 32'h3000; d_ss = 16'd2; d_dst = 32'h9000_0040; d_ds = 16'd0;
        d_word = 32'd6; d_size = 2'd1; d_major = 2; d_sl = 0; d_dl = 0;
        do_start();
        for (int k = 0; k < 10; k++) begin
            tick(k % 3 != 1);
            check("R9 fixed dst", dst_addr, 32'h9000_0040);
        end

        // R4 short count with enable set, offset bits nonzero
        d_src = 32'h500; d_ss = 16'd1; d_dst = 32'h600; d_ds = 16'd1;
        d_word = pack_word(0, 1, 1, 4); d_size = 2'd0; d_major = 5;
        do_start();
        seen = 0;
        for (int k = 0; k < 4; k++) begin tick(1); if (minor_done) seen = k + 1; end
        check("R4 short count beats", 32'(seen), 32'd4);
        // R4 enables clear: bits 29:0 form count 1028
        d_word = pack_word(0, 0, 1, 4);
        do_start();
        seen = 0;
        for (int k = 0; k < 4; k++) begin tick(1); if (minor_done) seen = 1; end
        check("R4 long count no end", 32'(seen), 32'd0);

        // R6 offset only on enabled side
        d_src = 32'h700; d_ss = 16'd1; d_dst = 32'h800; d_ds = 16'd0;
        d_word = pack_word(0, 1, 16, 3); d_size = 2'd0; d_major = 4;
        do_start();
        repeat (3) tick(1);
        check("R6 src no offset", src_addr, 32'h703);
        check("R6 dst offset", dst_addr, 32'h810);

        // R10 restart mid-run
        d_src = 32'hA00; d_ss = 16'd4; d_dst = 32'hB00; d_ds = 16'd4;
        d_word = 32'd16; d_size = 2'd2; d_major = 2;
        do_start();
        repeat (3) tick(1);
        d_src = 32'hC00; d_dst = 32'hD00; d_word = 32'd8;
        do_start();
        check("R10 restart src", src_addr, 32'hC00);
        tick(1);
        tick(1);
        check("R10 restart minor", {31'd0, minor_done}, 32'd1);

        // random descriptors with random accept
        for (int r = 0; r < 40; r++) begin
            bit se, de;
            int nb;
            se = $urandom_range(0, 1); de = $urandom_range(0, 1);
            nb = $urandom_range(1, 12);
            d_src = $urandom; d_dst = $urandom;
            d_ss = 16'($signed($urandom_range(0, 16)) - 8);
            d_ds = 16'($signed($urandom_range(0, 16)) - 8);
            d_word = pack_word(se, de, $signed($urandom_range(0, 64)) - 32, nb);
            d_sl = $urandom; d_dl = $urandom;
            d_major = 15'($urandom_range(1, 4));
            d_size = 2'($urandom_range(0, 3));
            do_start();
            for (int k = 0; k < 60; k++) tick($urandom_range(0, 3) != 0);
        end

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule